// File: doc/BRIEF.md
# Power-Fail Gated Parallel Register Bus

This block sits between an asynchronous parallel host bus and a bank of registers. The bus has an active-low select, an active-low output enable and an active-low write enable. The block turns these signals into a level read enable and a one-cycle write commit strobe in the system clock domain. It also decides when the block may drive the shared data bus. A chip-enable for an external memory passes through the block, but only while the supply is healthy.

Two supply flags stand in for analog comparators. One reports that the supply is above the trip point. The other reports that it is above the battery switch-over point. When either flag drops, the block behaves as deselected: it does not drive the bus, it commits no write and it holds the external memory enable inactive. Below switch-over it reports a retention state. After the supply returns, access stays blocked until the healthy condition has lasted a set number of clocks.

Every bus and supply input passes through two synchronizer flops before any decision is made. A write opens when the later of select or write-enable goes low. It is committed on the first clock in which the synchronized write condition is gone.

Top module: `pfg_regbus`

## Requirements
- R1: For as long as reset is held low, and again in the first cycle after it is released, `host_drive` and `reg_wr_stb` are 0, `xmem_ce_out_n` is 1 and `sup_state` is not 0.
- R2: `reg_rd_en` and `host_drive` are 1 when all of these hold: access is allowed; at the second clock edge after the inputs are applied, select and output enable are low and write enable is high. In that case `host_rdata` equals `reg_rdata` and `reg_rd_addr` equals the address that was applied. Otherwise `host_rdata` is 0.
- R3: When select is low and both output enable and write enable are high, `host_drive` and `reg_rd_en` stay 0.
- R4: When select and write enable are both low, the block is in write mode whatever the output enable level is, and `host_drive` is 0. If output enable is already low before write enable falls, the bus is driven with read data first. Driving stops at the same synchronized edge at which write enable is seen low.
- R5: A write starts at whichever of select or write enable goes low last. Once either one rises, `reg_wr_stb` pulses high for exactly one cycle, one clock after the synchronized write condition ends. With the strobe, `reg_wr_addr` and `reg_wr_data` carry the address and data that were synchronized in the last cycle of the write.
- R6: If access is withdrawn while a write is open, that write produces no strobe.
- R7: While the supply is not qualified, the block never drives the bus and never strobes, whatever the host does.
- R8: `xmem_ce_out_n` equals `xmem_ce_in_n` while access is allowed, and is 1 otherwise.
- R9: After both supply flags return high together, access is allowed once they have stayed high, synchronized, for HOLD_CYCLES clocks. The first allowed cycle is seen HOLD_CYCLES+2 edges after the flags rise.
- R10: `sup_state` encodes the supply state as follows: 0 means access is allowed; 1 means deselected or still qualifying; 2 means retention, which applies whenever the synchronized switch-over flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Host select, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Read data toward host, 0 when not driving |
| host_drive | output | 1 | Data bus output enable |
| sup_trip_ok | input | 1 | Supply above trip point |
| sup_sw_ok | input | 1 | Supply above switch-over point |
| xmem_ce_in_n | input | 1 | External memory enable from host |
| xmem_ce_out_n | output | 1 | Gated external memory enable |
| reg_rd_en | output | 1 | Register read enable |
| reg_rd_addr | output | ADDR_W | Register read address |
| reg_rdata | input | DATA_W | Data from register bank |
| reg_wr_stb | output | 1 | One-cycle write commit |
| reg_wr_addr | output | ADDR_W | Committed write address |
| reg_wr_data | output | DATA_W | Committed write data |
| sup_state | output | 2 | Supply state code |

## Verification
The decoder is driven with several orderings. In one, select falls before write enable; in another, write enable falls first. Writes are closed by raising select in some cases and write enable in others. These orderings show whether the start and the commit follow the later fall and the earlier rise. Plain reads, and reads with output enable held high, show the difference between driving and a selected bus that stays at high impedance. A read that turns into a write shows that driving stops when write enable is seen. Supply drops in the middle of a write and during a read, a retention interval and a timed requalification show whether the supply gate overrides every host pattern. They also show that the hold-off count is exact.

// File: rtl/pfg_pkg.sv
// Shared types for the power-fail gated register bus.
package pfg_pkg;

    // Supply state reported to the system; codes are part of the interface.
    typedef enum logic [1:0] {
        SUP_NORMAL   = 2'd0,
        SUP_DESELECT = 2'd1,
        SUP_RETAIN   = 2'd2
    } sup_state_t;

endpackage

// File: rtl/pfg_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is allowed to settle independently. Multi-bit fields
// (address, data) are taken to be stable while the strobes that qualify
// them are active.
module pfg_sync #(
    parameter int         W      = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two-stage shift toward the system clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pfg_supply.sv
// Supply qualifier: combines the synchronized trip and switch-over flags.
// Access is allowed only after both flags have stayed high for HOLD_CYCLES
// clocks. Assumes the flags are already synchronized.
module pfg_supply
    import pfg_pkg::*;
#(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_ok_s,
    input  logic       sw_ok_s,
    output logic       access_ok,
    output sup_state_t state
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYCLES);

    logic          pg;
    logic [CW-1:0] held;

    assign pg = trip_ok_s & sw_ok_s;

    // Count healthy cycles and saturate at the hold limit; clear on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (!pg) begin
            held <= '0;
        end else if (held != HOLD_V) begin
            held <= held + 1'b1;
        end
    end

    assign access_ok = pg && (held == HOLD_V);

    // Encode the reported supply state.
    always_comb begin
        if (!sw_ok_s)       state = SUP_RETAIN;
        else if (access_ok) state = SUP_NORMAL;
        else                state = SUP_DESELECT;
    end

    AST_QUAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_ok) |-> $past(pg)) else $error("qualify early"); // R9
    AST_RETAIN_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SUP_RETAIN) |=> !$past(access_ok)) else $error("retain access"); // R10
endmodule

// File: rtl/pfg_decode.sv
// Bus mode decoder on synchronized strobes. It produces the read enable and
// a one-cycle write commit at the end of a write. The address and data are
// captured while the write is open. Assumes the host keeps the address
// stable for the whole access.
module pfg_decode #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              oe_n_s,
    input  logic              we_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] wdata_s,
    input  logic              access_ok,
    output logic              rd_en,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic wr_on;
    logic wr_open;

    // Write mode needs select and write enable; output enable is ignored.
    assign wr_on = !sel_n_s && !we_n_s && access_ok;
    // Read mode needs select and output enable with write enable high.
    assign rd_en = !sel_n_s && !oe_n_s && we_n_s && access_ok;

    // Track the open write and commit it on the first cycle it closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open <= 1'b0;
            wr_stb  <= 1'b0;
        end else begin
            wr_open <= wr_on;
            wr_stb  <= wr_open && !wr_on && access_ok;
        end
    end

    // Capture the latest address and data while the write is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (wr_on) begin
            wr_addr <= addr_s;
            wr_data <= wdata_s;
        end
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb) else $error("strobe too long"); // R5
    AST_COMMIT_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(access_ok)) else $error("commit without power"); // R6
endmodule

// File: rtl/pfg_regbus.sv
// Top: power-fail gated parallel register bus. It synchronizes the host
// strobes and supply flags, qualifies the supply, decodes read and write
// modes, and gates the external memory enable. Assumes a free-running
// system clock that is much faster than host access times.
module pfg_regbus
    import pfg_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int HOLD_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_oe_n,
    input  logic              host_we_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_drive,
    input  logic              sup_trip_ok,
    input  logic              sup_sw_ok,
    input  logic              xmem_ce_in_n,
    output logic              xmem_ce_out_n,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr_stb,
    output logic [ADDR_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic [1:0]        sup_state
);
    localparam int BUS_W = 3 + ADDR_W + DATA_W;

    logic [2:0]        ctl_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] wdata_s;
    logic [1:0]        sup_s;
    logic              access_ok;
    sup_state_t        state;

    pfg_sync #(.W(BUS_W), .RST_VAL({3'b111, {(ADDR_W + DATA_W){1'b0}}})) i_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_sel_n, host_oe_n, host_we_n, host_addr, host_wdata}),
        .q     ({ctl_s, addr_s, wdata_s})
    );

    pfg_sync #(.W(2), .RST_VAL(2'b00)) i_sup_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sup_trip_ok, sup_sw_ok}),
        .q     (sup_s)
    );

    pfg_supply #(.HOLD_CYCLES(HOLD_CYCLES)) i_supply (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_ok_s (sup_s[1]),
        .sw_ok_s   (sup_s[0]),
        .access_ok (access_ok),
        .state     (state)
    );

    pfg_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (ctl_s[2]),
        .oe_n_s    (ctl_s[1]),
        .we_n_s    (ctl_s[0]),
        .addr_s    (addr_s),
        .wdata_s   (wdata_s),
        .access_ok (access_ok),
        .rd_en     (reg_rd_en),
        .wr_stb    (reg_wr_stb),
        .wr_addr   (reg_wr_addr),
        .wr_data   (reg_wr_data)
    );

    // Data bus driven only in read mode; the read address follows the bus.
    assign host_drive  = reg_rd_en;
    assign host_rdata  = reg_rd_en ? reg_rdata : '0;
    assign reg_rd_addr = addr_s;

    // External memory enable passes through only while access is allowed.
    assign xmem_ce_out_n = xmem_ce_in_n | ~access_ok;
    assign sup_state     = state;

    AST_DRIVE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        host_drive |-> (sup_state == 2'd0)) else $error("drive unpowered"); // R7
    AST_XMEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_state != 2'd0) |-> xmem_ce_out_n) else $error("xmem enabled"); // R8
endmodule

// File: tb/test_pfg_regbus.sv
module test_pfg_regbus;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int HOLD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic trip = 1'b1, sw = 1'b1, ce_in_n = 1'b1;
    logic [DW-1:0] rdata, reg_rdata, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic drive, ce_out_n, rd_en, wr_stb;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int stb_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    assign reg_rdata = {3'b000, rd_addr} ^ 8'hA5;

    pfg_regbus #(.ADDR_W(AW), .DATA_W(DW), .HOLD_CYCLES(HOLD)) i_pfg_regbus (
        .clk(clk), .rst_n(rst_n),
        .host_sel_n(sel_n), .host_oe_n(oe_n), .host_we_n(we_n),
        .host_addr(addr), .host_wdata(wdata),
        .host_rdata(rdata), .host_drive(drive),
        .sup_trip_ok(trip), .sup_sw_ok(sw),
        .xmem_ce_in_n(ce_in_n), .xmem_ce_out_n(ce_out_n),
        .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rdata(reg_rdata),
        .reg_wr_stb(wr_stb), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .sup_state(state)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference: two-deep history of sampled inputs plus state.
    logic m1_sel, m1_oe, m1_we, m2_sel, m2_oe, m2_we;
    logic [AW-1:0] m1_addr, m2_addr, m_waddr;
    logic [DW-1:0] m1_data, m2_data, m_wdata;
    logic m1_trip, m1_sw, m2_trip, m2_sw;
    int   m_cnt;
    logic m_open, m_stb;

    function automatic bit m_ok();
        return m2_trip && m2_sw && (m_cnt == HOLD);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m1_sel, m1_oe, m1_we, m2_sel, m2_oe, m2_we} = 6'b111111;
            m1_addr = '0; m2_addr = '0; m1_data = '0; m2_data = '0;
            m_waddr = '0; m_wdata = '0;
            {m1_trip, m1_sw, m2_trip, m2_sw} = 4'b0000;
            m_cnt = 0; m_open = 1'b0; m_stb = 1'b0;
        end else begin
            bit ok_o, wc;
            ok_o = m_ok();
            wc = !m2_sel && !m2_we && ok_o;
            m_stb = m_open && !wc && ok_o;
            if (wc) begin m_waddr = m2_addr; m_wdata = m2_data; end
            m_open = wc;
            if (!(m2_trip && m2_sw)) m_cnt = 0;
            else if (m_cnt < HOLD) m_cnt = m_cnt + 1;
            {m2_sel, m2_oe, m2_we, m2_addr, m2_data} = {m1_sel, m1_oe, m1_we, m1_addr, m1_data};
            {m2_trip, m2_sw} = {m1_trip, m1_sw};
            {m1_sel, m1_oe, m1_we, m1_addr, m1_data} = {sel_n, oe_n, we_n, addr, wdata};
            {m1_trip, m1_sw} = {trip, sw};
        end
    end

    // Compare every output with the reference away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit ok, erd;
            logic [1:0] est;
            ok = m_ok();
            erd = !m2_sel && !m2_oe && m2_we && ok;
            est = !m2_sw ? 2'd2 : (ok ? 2'd0 : 2'd1);
            chk(rd_en == erd, "R2 rd_en", rd_en, erd);
            chk(drive == erd, "R2 drive", drive, erd);
            chk(rdata == (erd ? reg_rdata : '0), "R2 rdata", rdata, erd ? reg_rdata : '0);
            if (erd) chk(rd_addr == m2_addr, "R2 rd_addr", rd_addr, m2_addr);
            chk(wr_stb == m_stb, "R5 wr_stb", wr_stb, m_stb);
            if (m_stb) begin
                chk(wr_addr == m_waddr, "R5 wr_addr", wr_addr, m_waddr);
                chk(wr_data == m_wdata, "R5 wr_data", wr_data, m_wdata);
            end
            chk(ce_out_n == (ce_in_n | !ok), "R8 xmem_ce", ce_out_n, ce_in_n | !ok);
            chk(state == est, "R10 sup_state", state, est);
            if (wr_stb) stb_cnt++;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write with a chosen start order (we_last) and end order (sel_first).
    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit we_last, input bit sel_first);
        @(negedge clk); addr = a; wdata = d;
        if (we_last) sel_n = 1'b0; else we_n = 1'b0;
        idle(2);
        sel_n = 1'b0; we_n = 1'b0;
        idle(4);
        if (sel_first) sel_n = 1'b1; else we_n = 1'b1;
        idle(2);
        sel_n = 1'b1; we_n = 1'b1;
        idle(4);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic oe);
        @(negedge clk); addr = a; sel_n = 1'b0; oe_n = oe; we_n = 1'b1;
        idle(5);
        sel_n = 1'b1; oe_n = 1'b1;
        idle(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int base, n;
        idle(3);
        // R1: reset state while held and right after release
        chk(drive == 1'b0 && wr_stb == 1'b0, "R1 outputs idle", {drive, wr_stb}, 0);
        chk(ce_out_n == 1'b1, "R1 xmem inactive", ce_out_n, 1);
        @(negedge clk); rst_n = 1'b1; ce_in_n = 1'b0;
        @(negedge clk);
        chk(state != 2'd0, "R1 not normal after reset", state, 1);
        chk(ce_out_n == 1'b1, "R1 xmem after reset", ce_out_n, 1);
        idle(HOLD + 4);
        chk(state == 2'd0, "R9 qualified after reset", state, 0);
        chk(ce_out_n == 1'b0, "R8 passthrough", ce_out_n, 0);

        bus_read(5'd3, 1'b0);
        bus_read(5'd17, 1'b0);
        // R3: selected with output enable high leaves the bus undriven
        @(negedge clk); addr = 5'd9; sel_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        idle(4);
        chk(drive == 1'b0 && rd_en == 1'b0, "R3 no drive oe high", drive, 0);
        sel_n = 1'b1; idle(3);

        // R5: all four start/end orderings each give one commit
        base = stb_cnt;
        bus_write(5'd1, 8'h11, 1'b1, 1'b1);
        bus_write(5'd2, 8'h22, 1'b0, 1'b1);
        bus_write(5'd30, 8'h33, 1'b1, 1'b0);
        bus_write(5'd31, 8'hC4, 1'b0, 1'b0);
        chk(stb_cnt == base + 4, "R5 one strobe per write", stb_cnt - base, 4);
        chk(wr_addr == 5'd31 && wr_data == 8'hC4, "R5 last write fields", {wr_addr, wr_data}, {5'd31, 8'hC4});

        // R4: read turning into a write; drive stops once we is seen
        @(negedge clk); addr = 5'd6; wdata = 8'h5A; sel_n = 1'b0; oe_n = 1'b0;
        idle(4);
        chk(drive == 1'b1, "R4 read before write", drive, 1);
        we_n = 1'b0;
        idle(2);
        chk(drive == 1'b0, "R4 drive off in write", drive, 0);
        idle(2);
        we_n = 1'b1; sel_n = 1'b1; oe_n = 1'b1;
        idle(4);
        chk(wr_addr == 5'd6 && wr_data == 8'h5A, "R4 write with oe low commits", {wr_addr, wr_data}, {5'd6, 8'h5A});

        // R6: supply drop during an open write commits nothing
        base = stb_cnt;
        @(negedge clk); addr = 5'd12; wdata = 8'hEE; sel_n = 1'b0; we_n = 1'b0;
        idle(4);
        trip = 1'b0;
        idle(4);
        sel_n = 1'b1; we_n = 1'b1;
        idle(4);
        chk(stb_cnt == base, "R6 no commit after drop", stb_cnt - base, 0);

        // R7: host read pattern while unpowered
        @(negedge clk); sel_n = 1'b0; oe_n = 1'b0; ce_in_n = 1'b0;
        idle(4);
        chk(drive == 1'b0, "R7 no drive unpowered", drive, 0);
        chk(ce_out_n == 1'b1, "R7 xmem forced off", ce_out_n, 1);
        sel_n = 1'b1; oe_n = 1'b1;

        // R9: exact requalification delay
        @(negedge clk); trip = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            if (state == 2'd0 || n > 50) break;
            n++;
        end
        chk(n == HOLD + 1, "R9 hold-off length", n, HOLD + 1);

        // R10: retention below switch-over
        @(negedge clk); sw = 1'b0;
        idle(3);
        chk(state == 2'd2, "R10 retention code", state, 2);
        bus_write(5'd7, 8'h77, 1'b1, 1'b1);
        @(negedge clk); sw = 1'b1;
        idle(HOLD + 4);
        chk(state == 2'd0, "R10 back to normal", state, 0);
        bus_read(5'd7, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule